// File: doc/BRIEF.md
# Nine-Bit UART Receive Buffer

This block is the receive-side holding buffer and error-status logic of a UART that can run in an optional nine-bit frame mode. A bit-level receive shifter, which is not part of this block, presents each completed frame for one cycle. The frame carries an eight-bit data byte, a ninth bit and three error indications: noise, framing and parity. The block stores the byte in a data register. It stores the ninth bit in the top bit of a separate control register, where that bit acts as the bit above the byte's msb. It also raises sticky error flags.

Software reaches the block over a small register bus. Reads have no wait states. A flag is cleared by a two-step sequence: first a status read that sees the flag set, then a data-register read. The data-register read also releases the buffer, so the next frame may overwrite both the byte and the ninth bit. For this reason software reads the ninth bit before the data register. A frame that arrives while the buffer is still full is dropped and the overrun flag is set. Each of the four error flags has its own enable bit. The enabled flags are combined into a single interrupt request.

Top module: `uart9_rx_buffer`

## Requirements
- R1: After a synchronous reset, the status register (offset 4), the format register (offset 2) and control register 3 (offset 6) all read 0, and `irq` is low.
- R2: A frame accepted into an empty buffer sets the full bit (status bit 5). Its byte then reads back at offset 7.
- R3: The format register holds the nine-bit mode select in bit 4. When that bit was set as a frame was accepted, the frame's ninth bit reads back as bit 7 of control register 3. When the bit was clear, control bit 7 reads 0.
- R4: A frame that arrives while the buffer is full and not being released leaves the byte and the ninth bit unchanged, and sets the overrun flag (status bit 3).
- R5: A flag or the full bit clears only on a data read that follows a status read which saw it set. A data read with no such status read clears nothing. A flag that sets after the status read survives the data read.
- R6: A frame's noise, framing and parity indications set status bits 2, 1 and 0. These bits are sticky until they are cleared as in R5.
- R7: `irq` is the OR, over the four flags, of each status bit 3..0 ANDed with the enable in the same position of control register 3 (overrun, noise, framing, parity).
- R8: A frame that arrives in the same cycle as a releasing data read is loaded into the buffer and does not set the overrun flag.
- R9: In control register 3, bits 6 to 4 read 0 and ignore writes. Offsets that no register decodes read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 3 | Register offset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (read side effects) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from `bus_addr` |
| frm_valid | input | 1 | One-cycle pulse: shifter has a completed frame |
| frm_byte | input | 8 | Received data byte |
| frm_bit9 | input | 1 | Received ninth bit |
| frm_noise | input | 1 | Noise seen in frame |
| frm_framing | input | 1 | Bad stop bit in frame |
| frm_parity | input | 1 | Parity mismatch in frame |
| irq | output | 1 | Combined error interrupt request |

## Verification
The bench sweeps all 16 enable settings against all 16 combinations of the four error flags, which covers every gating of the interrupt. Overrun is produced by sending a second frame carrying a different byte and ninth bit, so a retained buffer can be told apart from an overwritten one. The nine-bit select alternates across the sweep, which separates a stored ninth bit from a masked one. Directed sequences then separate a data read that clears from one that does not, and show that a flag set after the status read survives. They also show that a frame arriving at the instant of release is loaded rather than counted as an overrun.

// File: rtl/uart9_rx_pkg.sv
package uart9_rx_pkg;
    localparam int BUS_W  = 8;
    localparam int ADDR_W = 3;
    localparam int NFLAG  = 4;

    localparam logic [ADDR_W-1:0] OFF_FMT  = 3'd2;
    localparam logic [ADDR_W-1:0] OFF_STAT = 3'd4;
    localparam logic [ADDR_W-1:0] OFF_CTL3 = 3'd6;
    localparam logic [ADDR_W-1:0] OFF_DATA = 3'd7;

    localparam int FMT_NINE_BIT  = 4;
    localparam int STAT_FULL_BIT = 5;
    localparam int CTL3_NINTH    = 7;

    // Bit order matches status bits 3..0 and enable bits 3..0.
    typedef struct packed {
        logic ovr;
        logic noise;
        logic framing;
        logic parity;
    } err_flags_t;

    typedef enum logic [1:0] {
        ACC_NONE,
        ACC_STATUS,
        ACC_DATA,
        ACC_OTHER
    } access_t;

    function automatic access_t decode_read(input logic rd, input logic [ADDR_W-1:0] a);
        if (!rd)              return ACC_NONE;
        else if (a == OFF_STAT) return ACC_STATUS;
        else if (a == OFF_DATA) return ACC_DATA;
        else                  return ACC_OTHER;
    endfunction

    function automatic logic [BUS_W-1:0] pack_status(input logic full, input err_flags_t f);
        logic [BUS_W-1:0] v;
        v = '0;
        v[STAT_FULL_BIT] = full;
        v[NFLAG-1:0]     = f;
        return v;
    endfunction
endpackage

// File: rtl/uart9_rx_frame_store.sv
module uart9_rx_frame_store
    import uart9_rx_pkg::*;
#(
    parameter int DW = BUS_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic          release_buf,
    input  logic [DW-1:0] din,
    input  logic          bit9_in,
    output logic [DW-1:0] data_q,
    output logic          bit9_q,
    output logic          full_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            data_q <= '0;
            bit9_q <= 1'b0;
            full_q <= 1'b0;
        end else if (load) begin
            data_q <= din;
            bit9_q <= bit9_in;
            full_q <= 1'b1;
        end else if (release_buf) begin
            full_q <= 1'b0;
        end
    end
endmodule

// File: rtl/uart9_rx_flag_unit.sv
module uart9_rx_flag_unit
    import uart9_rx_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  access_t    acc,
    input  logic       full_in,
    input  err_flags_t set_flags,
    output err_flags_t flags_q,
    output logic       release_buf
);
    err_flags_t seen_q;
    logic       seen_full_q;
    err_flags_t clr_mask;

    assign release_buf = (acc == ACC_DATA) && seen_full_q;
    assign clr_mask    = (acc == ACC_DATA) ? seen_q : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            flags_q     <= '0;
            seen_q      <= '0;
            seen_full_q <= 1'b0;
        end else begin
            flags_q <= (flags_q & ~clr_mask) | set_flags;
            if (acc == ACC_STATUS) begin
                seen_q      <= flags_q;
                seen_full_q <= full_in;
            end else if (acc == ACC_DATA) begin
                seen_q      <= '0;
                seen_full_q <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/uart9_rx_irq_merge.sv
module uart9_rx_irq_merge
    import uart9_rx_pkg::*;
#(
    parameter int N = NFLAG
) (
    input  logic [N-1:0] flags,
    input  logic [N-1:0] enables,
    output logic         irq
);
    logic [N-1:0] gated;
    for (genvar g = 0; g < N; g++) begin : g_gate
        assign gated[g] = flags[g] & enables[g];
    end
    assign irq = |gated;
endmodule

// File: rtl/uart9_rx_buffer.sv
module uart9_rx_buffer
    import uart9_rx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    input  logic              frm_valid,
    input  logic [BUS_W-1:0]  frm_byte,
    input  logic              frm_bit9,
    input  logic              frm_noise,
    input  logic              frm_framing,
    input  logic              frm_parity,
    output logic              irq
);
    logic             nine_mode;
    logic [NFLAG-1:0] en_q;
    logic [BUS_W-1:0] data_q;
    logic             bit9_q;
    logic             full_q;
    logic             release_buf;
    logic             load;
    err_flags_t       flags_q;
    err_flags_t       set_flags;
    access_t          acc;

    assign acc  = decode_read(bus_rd, bus_addr);
    assign load = frm_valid && (!full_q || release_buf);

    always_comb begin
        set_flags         = '0;
        set_flags.ovr     = frm_valid && full_q && !release_buf;
        set_flags.noise   = load && frm_noise;
        set_flags.framing = load && frm_framing;
        set_flags.parity  = load && frm_parity;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            nine_mode <= 1'b0;
            en_q      <= '0;
        end else if (bus_wr) begin
            if (bus_addr == OFF_FMT)  nine_mode <= bus_wdata[FMT_NINE_BIT];
            if (bus_addr == OFF_CTL3) en_q      <= bus_wdata[NFLAG-1:0];
        end
    end

    uart9_rx_frame_store #(.DW(BUS_W)) u_store (
        .clk        (clk),
        .rst        (rst),
        .load       (load),
        .release_buf(release_buf),
        .din        (frm_byte),
        .bit9_in    (frm_bit9 & nine_mode),
        .data_q     (data_q),
        .bit9_q     (bit9_q),
        .full_q     (full_q)
    );

    uart9_rx_flag_unit u_flags (
        .clk        (clk),
        .rst        (rst),
        .acc        (acc),
        .full_in    (full_q),
        .set_flags  (set_flags),
        .flags_q    (flags_q),
        .release_buf(release_buf)
    );

    uart9_rx_irq_merge #(.N(NFLAG)) u_irq (
        .flags  (flags_q),
        .enables(en_q),
        .irq    (irq)
    );

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            OFF_FMT:  bus_rdata[FMT_NINE_BIT] = nine_mode;
            OFF_STAT: bus_rdata = pack_status(full_q, flags_q);
            OFF_CTL3: begin
                bus_rdata[CTL3_NINTH]  = bit9_q;
                bus_rdata[NFLAG-1:0]   = en_q;
            end
            OFF_DATA: bus_rdata = data_q;
            default:  bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/uart9_rx_checker.sv
module uart9_rx_checker
    import uart9_rx_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              bus_rd,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              frm_valid,
    input logic              full_q,
    input logic              release_buf,
    input logic [BUS_W-1:0]  data_q,
    input logic              bit9_q,
    input logic              nine_mode,
    input err_flags_t        flags_q,
    input logic [NFLAG-1:0]  en_q,
    input logic              irq
);
    p_reset_clear_r1: assert property (@(posedge clk)
        rst |=> (!full_q && flags_q == '0 && en_q == '0 && !irq));

    p_hold_on_overrun_r4: assert property (@(posedge clk) disable iff (rst)
        (frm_valid && full_q && !release_buf) |=> ($stable(data_q) && $stable(bit9_q) && flags_q.ovr));

    p_full_clear_by_read_r5: assert property (@(posedge clk) disable iff (rst)
        $fell(full_q) |-> $past(bus_rd && bus_addr == OFF_DATA));

    p_ovr_clear_by_read_r5: assert property (@(posedge clk) disable iff (rst)
        $fell(flags_q.ovr) |-> $past(bus_rd && bus_addr == OFF_DATA));

    p_ninth_masked_r3: assert property (@(posedge clk) disable iff (rst)
        ($rose(full_q) && !$past(nine_mode)) |-> !bit9_q);

    p_irq_quiet_r7: assert property (@(posedge clk) disable iff (rst)
        (en_q == '0) |-> !irq);

    p_load_on_release_r8: assert property (@(posedge clk) disable iff (rst)
        (frm_valid && release_buf) |=> (full_q && !$rose(flags_q.ovr)));
endmodule

bind uart9_rx_buffer uart9_rx_checker u_chk (
    .clk        (clk),
    .rst        (rst),
    .bus_rd     (bus_rd),
    .bus_addr   (bus_addr),
    .frm_valid  (frm_valid),
    .full_q     (full_q),
    .release_buf(release_buf),
    .data_q     (data_q),
    .bit9_q     (bit9_q),
    .nine_mode  (nine_mode),
    .flags_q    (flags_q),
    .en_q       (en_q),
    .irq        (irq)
);

// File: tb/tb_uart9_rx_buffer.sv
module tb_uart9_rx_buffer;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] bus_addr = '0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       frm_valid = 1'b0;
    logic [7:0] frm_byte = '0;
    logic       frm_bit9 = 1'b0;
    logic       frm_noise = 1'b0;
    logic       frm_framing = 1'b0;
    logic       frm_parity = 1'b0;
    logic       irq;

    int  n_checks = 0;
    int  n_fail = 0;
    bit  done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    uart9_rx_buffer dut (.*);

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_read(input logic [2:0] a, output logic [7:0] v);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 v = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic bus_write(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic peek(input logic [2:0] a, output logic [7:0] v);
        @(negedge clk);
        bus_addr = a;
        #1 v = bus_rdata;
    endtask

    task automatic send(input logic [7:0] b, input logic n9, input logic [2:0] e);
        @(negedge clk);
        frm_valid = 1'b1; frm_byte = b; frm_bit9 = n9;
        {frm_noise, frm_framing, frm_parity} = e;
        @(negedge clk);
        frm_valid = 1'b0; {frm_noise, frm_framing, frm_parity} = '0;
    endtask

    initial begin
        logic [7:0] v;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        peek(3'd4, v); check("R1 status", v, 8'h00);
        peek(3'd2, v); check("R1 format", v, 8'h00);
        peek(3'd6, v); check("R1 ctl3", v, 8'h00);
        check("R1 irq", {7'b0, irq}, 8'h00);

        // Sweep: enables x flag combinations, alternating nine-bit mode
        for (int i = 0; i < 256; i++) begin
            logic [3:0] en, fl;
            logic [7:0] d;
            logic       b9, mode;
            en = i[7:4]; fl = i[3:0];
            d = 8'((i * 37 + 5) & 8'hFF);
            b9 = i[2] ^ i[6];
            mode = i[0] ^ i[5];
            bus_write(3'd2, {3'b000, mode, 4'b0000});
            bus_write(3'd6, {4'b1110, en});
            send(d, b9, fl[2:0]);
            if (fl[3]) send(~d, ~b9, 3'b000);
            @(negedge clk);
            check("R7 irq gating", {7'b0, irq}, {7'b0, |(fl & en)});
            bus_read(3'd4, v);
            check("R6 status flags", v, {2'b00, 1'b1, 1'b0, fl});
            bus_read(3'd6, v);
            check("R3 ninth bit / R9 ctl3 bits", v, {b9 & mode, 3'b000, en});
            bus_read(3'd7, v);
            check("R2 R4 data byte", v, d);
            bus_read(3'd4, v);
            check("R5 cleared", v, 8'h00);
            check("R7 irq after clear", {7'b0, irq}, 8'h00);
        end

        bus_write(3'd6, 8'h0F);
        // R5: data read without a status read does not clear
        send(8'hA5, 1'b0, 3'b100);
        bus_read(3'd7, v);
        check("R5 data read alone", v, 8'hA5);
        peek(3'd4, v); check("R5 flags kept", v, 8'h24);
        // R5: flag set after the status read survives the data read
        bus_read(3'd4, v);
        send(8'h11, 1'b0, 3'b000);   // overrun after status read
        bus_read(3'd7, v);
        check("R4 data kept", v, 8'hA5);
        peek(3'd4, v); check("R5 late overrun survives", v, 8'h08);
        check("R7 irq overrun", {7'b0, irq}, 8'h01);
        bus_read(3'd4, v); bus_read(3'd7, v);
        peek(3'd4, v); check("R5 overrun cleared", v, 8'h00);

        // R8: frame at the releasing data read
        send(8'h3C, 1'b0, 3'b000);
        bus_read(3'd4, v);
        @(negedge clk);
        bus_addr = 3'd7; bus_rd = 1'b1;
        frm_valid = 1'b1; frm_byte = 8'hC3; frm_bit9 = 1'b0;
        #1 check("R8 old byte read", bus_rdata, 8'h3C);
        @(negedge clk);
        bus_rd = 1'b0; frm_valid = 1'b0;
        peek(3'd4, v); check("R8 loaded without overrun", v, 8'h20);
        peek(3'd7, v); check("R8 new byte", v, 8'hC3);

        // R9 undecoded offsets
        for (int a = 0; a < 8; a++) begin
            if (a != 2 && a != 4 && a != 6 && a != 7) begin
                peek(3'(a), v); check("R9 undecoded read", v, 8'h00);
            end
        end
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end
endmodule